// File: doc/BRIEF.md
# DMA Segment Descriptor Queue

This block holds a short list of DMA segment descriptors between the software that builds a scatter-gather transfer and the engine that moves the data. Software first writes a segment's bus address into a staging register. It then writes a command word that carries the segment length, the transfer direction, a byte-swap flag and an interrupt-suppress flag. The command write joins the staged address and the command into a single queue entry.

The DMA engine sees the oldest entry on a head port with a valid flag. It takes the entry with a one-cycle pop strobe. When the engine reports that the segment it last took has completed, the block raises an interrupt pulse, unless that segment's suppress flag was set. Software normally sets the suppress flag on every segment except the last one, so the whole list produces a single interrupt.

A configuration register reports the number of pending entries and two sticky error flags. It also holds a clear bit: while that bit is set the queue is empty and rejects new entries.

Top module: `dma_desc_queue`

## Requirements
- R1: After reset the queue is disabled (configuration bit 16 reads 1), the entry count (configuration bits [CNT_W-1:0]) is 0, both error flags read 0, `head_valid` is 0 and `irq_pulse` is 0.
- R2: A write with `wr_sel`=1 only stages `wr_data` as the next segment address. The entry count and the head port are unchanged.
- R3: A write with `wr_sel`=2 (command) commits one entry when the queue is enabled, not full and the staged address has bits [2:0] clear. The entry's length-minus-one is taken from bits [15:0], direction from bit 16, swap from bit 17 and interrupt-suppress from bit 18. The count rises by one at the next clock edge.
- R4: Entries leave in the order they were committed. `head_valid` is 1 exactly when the count is non-zero, and the head port shows the oldest entry's fields.
- R5: A `pop` while `head_valid` is 1 removes the head entry and lowers the count at the same clock edge. A `pop` while the queue is empty has no effect.
- R6: The queue holds at most DEPTH entries. A command write while the count equals DEPTH is dropped and sets the sticky overflow flag (configuration bit 8).
- R7: A command write while the queue is disabled is dropped and sets the overflow flag.
- R8: A command write whose staged address has any of bits [2:0] set is dropped and sets the sticky alignment flag (configuration bit 9).
- R9: A configuration write (`wr_sel`=0) loads the clear bit from `wr_data[16]` and zeroes both sticky flags. When `wr_data[16]` is 1 the queue empties at the same edge, and this takes priority over a `pop` in that cycle. Writing 0 enables the queue.
- R10: A command write and a pop in the same cycle on a non-full queue leave the count unchanged and keep the order.
- R11: `seg_done` produces a one-cycle `irq_pulse` on the following cycle if the most recently popped entry had its suppress flag clear. If that flag was set, or no entry has been popped since reset, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 config, 1 address, 2 command, 3 none |
| wr_data | input | 64 | Register write data |
| cfg_rdata | output | 32 | Config view: count, overflow (bit 8), alignment (bit 9), clear (bit 16) |
| head_valid | output | 1 | Head entry present |
| head_addr | output | 64 | Head segment bus address |
| head_len_m1 | output | 16 | Head segment length in 8-byte words minus one |
| head_dir | output | 1 | Head direction bit |
| head_swap | output | 1 | Head byte-swap bit |
| head_irq_off | output | 1 | Head interrupt-suppress bit |
| pop | input | 1 | Engine takes the head entry |
| seg_done | input | 1 | Engine finished the last taken segment |
| irq_pulse | output | 1 | Completion interrupt pulse |

## Verification
The bench builds the queue with DEPTH=4. With that depth the full boundary, overflow drops and pointer wrap-around come up many times within a few hundred cycles, instead of only once at depth 16. The length field stays at its full 16 bits, so the command-word bit positions are those used in production. A long mixed phase of pushes, pops, misaligned addresses and clears runs at this small depth, so the clear-while-full and push-with-pop-at-the-boundary cases are reached repeatedly.

// File: rtl/dq_pkg.sv
package dq_pkg;

    localparam int unsigned DQ_ADDR_W  = 64;
    localparam int unsigned DQ_LEN_W   = 16;
    localparam int unsigned DQ_CFG_W   = 32;
    localparam int unsigned ALIGN_BITS = 3;

    // command word bit positions
    localparam int unsigned CMD_DIR_BIT  = DQ_LEN_W;
    localparam int unsigned CMD_SWAP_BIT = DQ_LEN_W + 1;
    localparam int unsigned CMD_IOFF_BIT = DQ_LEN_W + 2;

    // configuration view bit positions
    localparam int unsigned CFG_OVF_BIT = 8;
    localparam int unsigned CFG_ALN_BIT = 9;
    localparam int unsigned CFG_CLR_BIT = 16;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DQ_ADDR_W-1:0] addr;
        logic [DQ_LEN_W-1:0]  len_m1;
        logic                 dir;
        logic                 swap;
        logic                 irq_off;
    } desc_t;

    function automatic desc_t make_desc(input logic [DQ_ADDR_W-1:0] addr,
                                        input logic [DQ_ADDR_W-1:0] cmd);
        desc_t d;
        d.addr    = addr;
        d.len_m1  = cmd[DQ_LEN_W-1:0];
        d.dir     = cmd[CMD_DIR_BIT];
        d.swap    = cmd[CMD_SWAP_BIT];
        d.irq_off = cmd[CMD_IOFF_BIT];
        return d;
    endfunction

    function automatic logic [DQ_CFG_W-1:0] pack_cfg(input logic clr,
                                                     input logic ovf,
                                                     input logic aln,
                                                     input logic [7:0] cnt);
        logic [DQ_CFG_W-1:0] v;
        v              = '0;
        v[7:0]         = cnt;
        v[CFG_OVF_BIT] = ovf;
        v[CFG_ALN_BIT] = aln;
        v[CFG_CLR_BIT] = clr;
        return v;
    endfunction

endpackage

// File: rtl/dq_regif.sv
module dq_regif
    import dq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  reg_sel_e             wr_sel,
    input  logic [DQ_ADDR_W-1:0] wr_data,
    input  logic                 full,
    output logic                 push,
    output desc_t                push_desc,
    output logic                 flush,
    output logic                 disabled,
    output logic                 ovf_flag,
    output logic                 aln_flag,
    output logic [DQ_ADDR_W-1:0] staged_addr
);

    logic cfg_wr, addr_wr, cmd_wr, misaligned;

    always_comb begin
        cfg_wr     = wr_en && (wr_sel == SEL_CFG);
        addr_wr    = wr_en && (wr_sel == SEL_ADDR);
        cmd_wr     = wr_en && (wr_sel == SEL_CMD);
        misaligned = |staged_addr[ALIGN_BITS-1:0];
        push       = cmd_wr && !disabled && !full && !misaligned;
        flush      = cfg_wr && wr_data[CFG_CLR_BIT];
        push_desc  = make_desc(staged_addr, wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            disabled    <= 1'b1;
            ovf_flag    <= 1'b0;
            aln_flag    <= 1'b0;
            staged_addr <= '0;
        end else begin
            if (addr_wr) begin
                staged_addr <= wr_data;
            end
            if (cmd_wr) begin
                if (disabled || full) ovf_flag <= 1'b1;
                if (misaligned)       aln_flag <= 1'b1;
            end
            if (cfg_wr) begin
                disabled <= wr_data[CFG_CLR_BIT];
                ovf_flag <= 1'b0;
                aln_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dq_store.sv
module dq_store
    import dq_pkg::*;
#(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  desc_t            push_desc,
    input  logic             pop_req,
    output logic             pop_acc,
    output logic             head_valid,
    output logic             full,
    output desc_t            head_desc,
    output logic [CNT_W-1:0] count
);

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    desc_t            slot_view [DEPTH];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        desc_t slot_r;
        always_ff @(posedge clk) begin
            if (push && (wr_ptr == PTR_W'(i))) begin
                slot_r <= push_desc;
            end
        end
        assign slot_view[i] = slot_r;
    end

    always_comb begin
        head_valid = (count != '0);
        full       = (count == CNT_W'(DEPTH));
        pop_acc    = pop_req && head_valid && !flush;
        head_desc  = slot_view[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)    wr_ptr <= step(wr_ptr);
            if (pop_acc) rd_ptr <= step(rd_ptr);
            case ({push, pop_acc})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/dq_irq.sv
module dq_irq (
    input  logic clk,
    input  logic rst,
    input  logic pop_acc,
    input  logic head_irq_off,
    input  logic seg_done,
    output logic irq_pulse
);

    // suppress flag of the segment most recently handed to the engine
    logic last_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_off  <= 1'b1;
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= seg_done && !last_off;
            if (pop_acc) last_off <= head_irq_off;
        end
    end

endmodule

// File: rtl/dma_desc_queue.sv
module dma_desc_queue
    import dq_pkg::*;
#(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [DQ_ADDR_W-1:0] wr_data,
    output logic [DQ_CFG_W-1:0]  cfg_rdata,
    output logic                 head_valid,
    output logic [DQ_ADDR_W-1:0] head_addr,
    output logic [DQ_LEN_W-1:0]  head_len_m1,
    output logic                 head_dir,
    output logic                 head_swap,
    output logic                 head_irq_off,
    input  logic                 pop,
    input  logic                 seg_done,
    output logic                 irq_pulse
);

    logic                 full, push, flush, disabled, ovf_flag, aln_flag, pop_acc;
    desc_t                push_desc, head_desc;
    logic [CNT_W-1:0]     q_count;
    logic [DQ_ADDR_W-1:0] staged_addr;

    dq_regif u_regif (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (reg_sel_e'(wr_sel)),
        .wr_data    (wr_data),
        .full       (full),
        .push       (push),
        .push_desc  (push_desc),
        .flush      (flush),
        .disabled   (disabled),
        .ovf_flag   (ovf_flag),
        .aln_flag   (aln_flag),
        .staged_addr(staged_addr)
    );

    dq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (push),
        .push_desc (push_desc),
        .pop_req   (pop),
        .pop_acc   (pop_acc),
        .head_valid(head_valid),
        .full      (full),
        .head_desc (head_desc),
        .count     (q_count)
    );

    dq_irq u_irq (
        .clk         (clk),
        .rst         (rst),
        .pop_acc     (pop_acc),
        .head_irq_off(head_desc.irq_off),
        .seg_done    (seg_done),
        .irq_pulse   (irq_pulse)
    );

    always_comb begin
        cfg_rdata    = pack_cfg(disabled, ovf_flag, aln_flag, 8'(q_count));
        head_addr    = head_desc.addr;
        head_len_m1  = head_desc.len_m1;
        head_dir     = head_desc.dir;
        head_swap    = head_desc.swap;
        head_irq_off = head_desc.irq_off;
    end

endmodule

// File: rtl/dq_chk.sv
module dq_chk #(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic        wr_clr,
    input logic        pop,
    input logic        seg_done,
    input logic        head_valid,
    input logic [31:0] cfg_rdata,
    input logic        irq_pulse,
    input logic [2:0]  staged_lo
);

    logic [CNT_W-1:0] cnt;
    logic             ovf, aln, dis;
    assign cnt = cfg_rdata[CNT_W-1:0];
    assign ovf = cfg_rdata[8];
    assign aln = cfg_rdata[9];
    assign dis = cfg_rdata[16];

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    // R4
    head_valid_chk: assert property (@(posedge clk) disable iff (rst)
        head_valid == (cnt != '0));

    // R3
    push_count_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && !dis && cnt < CNT_W'(DEPTH) &&
         staged_lo == 3'd0 && !(pop && head_valid))
        |=> cnt == $past(cnt) + 1'b1);

    // R5
    pop_count_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && head_valid && !wr_en) |=> cnt == $past(cnt) - 1'b1);

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && cnt == CNT_W'(DEPTH)) |=> ovf);

    // R7
    disabled_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && dis) |=> (ovf && cnt == '0));

    // R8
    align_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && staged_lo != 3'd0) |=> aln);

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && wr_clr) |=> (cnt == '0 && dis && !ovf && !aln));

    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(seg_done));

endmodule

bind dma_desc_queue dq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_clr    (wr_data[16]),
    .pop       (pop),
    .seg_done  (seg_done),
    .head_valid(head_valid),
    .cfg_rdata (cfg_rdata),
    .irq_pulse (irq_pulse),
    .staged_lo (staged_addr[2:0])
);

// File: tb/tb_dma_desc_queue.sv
module tb_dma_desc_queue;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [63:0] wr_data = '0;
    logic        pop = 1'b0;
    logic        seg_done = 1'b0;
    logic [31:0] cfg_rdata;
    logic        head_valid, head_dir, head_swap, head_irq_off, irq_pulse;
    logic [63:0] head_addr;
    logic [15:0] head_len_m1;

    always #2.5 clk = ~clk;

    dma_desc_queue #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cfg_rdata(cfg_rdata), .head_valid(head_valid), .head_addr(head_addr),
        .head_len_m1(head_len_m1), .head_dir(head_dir), .head_swap(head_swap),
        .head_irq_off(head_irq_off), .pop(pop), .seg_done(seg_done),
        .irq_pulse(irq_pulse)
    );

    // ---------------- reference model ----------------
    typedef struct {
        logic [63:0] a;
        logic [15:0] l;
        bit d, s, o;
    } mdesc_t;

    mdesc_t      mq[$];
    bit          m_dis, m_ovf, m_aln, m_last_off, m_irq;
    logic [63:0] m_stage;
    bit          cfgw, addrw, cmdw, fullb, popok;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            m_dis = 1; m_ovf = 0; m_aln = 0; m_last_off = 1; m_irq = 0;
            m_stage = '0;
        end else begin
            cfgw  = wr_en && wr_sel == 2'd0;
            addrw = wr_en && wr_sel == 2'd1;
            cmdw  = wr_en && wr_sel == 2'd2;
            fullb = (mq.size() == DEPTH);
            m_irq = seg_done && !m_last_off;
            popok = pop && mq.size() > 0 && !(cfgw && wr_data[16]);
            if (popok) begin
                m_last_off = mq[0].o;
                void'(mq.pop_front());
            end
            if (cmdw) begin
                if (m_dis || fullb) m_ovf = 1;
                if (m_stage[2:0] != 0) m_aln = 1;
                if (!m_dis && !fullb && m_stage[2:0] == 0) begin
                    mdesc_t e;
                    e.a = m_stage; e.l = wr_data[15:0];
                    e.d = wr_data[16]; e.s = wr_data[17]; e.o = wr_data[18];
                    mq.push_back(e);
                end
            end
            if (cfgw) begin
                m_dis = wr_data[16]; m_ovf = 0; m_aln = 0;
                if (wr_data[16]) mq.delete();
            end
            if (addrw) m_stage = wr_data;
        end
    end

    // ---------------- checking ----------------
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    cmp_on   = 0;
    bit    ended    = 0;
    string tag      = "R1";

    task automatic chk(input string t, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", t, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_cfg();
        logic [31:0] v = '0;
        v[7:0] = 8'(mq.size());
        v[8]   = m_ovf;
        v[9]   = m_aln;
        v[16]  = m_dis;
        return v;
    endfunction

    always @(negedge clk) begin
        if (cmp_on && !ended) begin
            chk(tag, "cfg", {32'b0, cfg_rdata}, {32'b0, exp_cfg()});
            chk(tag, "head_valid", {63'b0, head_valid}, {63'b0, mq.size() > 0});
            chk(tag, "irq", {63'b0, irq_pulse}, {63'b0, m_irq});
            if (mq.size() > 0) begin
                chk(tag, "head_addr", head_addr, mq[0].a);
                chk(tag, "head_fields",
                    {45'b0, head_irq_off, head_swap, head_dir, head_len_m1},
                    {45'b0, mq[0].o, mq[0].s, mq[0].d, mq[0].l});
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input logic we, input logic [1:0] sel, input logic [63:0] d,
                         input logic p, input logic sd);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; pop = p; seg_done = sd;
        @(posedge clk);
        #1;
        wr_en = 0; wr_sel = 2'd3; pop = 0; seg_done = 0;
    endtask

    function automatic logic [63:0] cmd(input logic [15:0] len, input bit d,
                                        input bit s, input bit o);
        return {45'b0, o, s, d, len};
    endfunction

    task automatic push(input logic [63:0] a, input logic [63:0] c);
        drive(1, 2'd1, a, 0, 0);
        drive(1, 2'd2, c, 0, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 2'd3, '0, 0, 0);
    endtask

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 0;
        cmp_on = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset cfg", {32'b0, cfg_rdata}, 64'h1_0000);
        chk("R1", "reset head_valid", {63'b0, head_valid}, 64'd0);
        chk("R1", "reset irq", {63'b0, irq_pulse}, 64'd0);

        tag = "R7";
        push(64'h1000, cmd(16'd7, 0, 0, 0));
        idle(1);
        chk("R7", "ovf after disabled push", {63'b0, cfg_rdata[8]}, 64'd1);

        tag = "R9";
        drive(1, 2'd0, 64'd0, 0, 0);
        idle(1);
        chk("R9", "enabled and flags clear", {32'b0, cfg_rdata}, 64'd0);

        tag = "R2";
        drive(1, 2'd1, 64'hDEAD_0000, 0, 0);
        idle(1);
        chk("R2", "count after addr write", {32'b0, cfg_rdata}, 64'd0);

        tag = "R3";
        push(64'h0000_0001_0000_0040, cmd(16'd1, 1, 0, 1));
        push(64'h0000_0000_8000_0008, cmd(16'hFFFF, 0, 1, 1));
        push(64'hFFFF_FFFF_FFFF_FFF8, cmd(16'd0, 1, 1, 0));
        idle(1);
        chk("R3", "count after three pushes", {32'b0, cfg_rdata}, 64'd3);
        tag = "R4";
        chk("R4", "first entry address", head_addr, 64'h0000_0001_0000_0040);

        tag = "R5";
        drive(0, 2'd3, '0, 1, 0);
        idle(1);
        chk("R5", "second entry after pop", head_addr, 64'h0000_0000_8000_0008);
        drive(0, 2'd3, '0, 1, 0);
        drive(0, 2'd3, '0, 1, 0);
        drive(0, 2'd3, '0, 1, 0);
        idle(1);
        chk("R5", "empty after pops", {32'b0, cfg_rdata}, 64'd0);

        tag = "R11";
        drive(0, 2'd3, '0, 0, 1);
        idle(1);
        push(64'h200, cmd(16'd3, 0, 0, 1));
        drive(0, 2'd3, '0, 1, 0);
        drive(0, 2'd3, '0, 0, 1);
        idle(1);
        chk("R11", "suppressed irq", {63'b0, irq_pulse}, 64'd0);

        tag = "R6";
        for (int i = 0; i < DEPTH + 1; i++) push(64'h100 * (i + 1), cmd(16'(i), i[0], i[1], 1));
        idle(1);
        chk("R6", "full count and overflow", {32'b0, cfg_rdata}, 64'h100 | DEPTH);

        tag = "R10";
        drive(1, 2'd2, cmd(16'd9, 0, 0, 0), 1, 0);
        drive(1, 2'd2, cmd(16'd9, 0, 0, 0), 1, 0);
        idle(1);
        chk("R10", "count with push and pop", {32'b0, cfg_rdata[7:0]}, 64'(DEPTH - 1));

        tag = "R9";
        drive(1, 2'd0, 64'h1_0000, 1, 0);
        idle(1);
        chk("R9", "clear empties", {32'b0, cfg_rdata}, 64'h1_0000);
        drive(1, 2'd0, 64'd0, 0, 0);

        tag = "R8";
        push(64'h1004, cmd(16'd2, 0, 0, 0));
        idle(1);
        chk("R8", "misaligned dropped", {32'b0, cfg_rdata}, 64'h200);

        tag = "R11";
        push(64'h3000, cmd(16'd5, 1, 0, 0));
        drive(0, 2'd3, '0, 1, 0);
        drive(0, 2'd3, '0, 0, 1);
        @(negedge clk);
        chk("R11", "irq pulse", {63'b0, irq_pulse}, 64'd1);

        tag = "R4";
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 15);
            logic [63:0] rd = {$urandom, $urandom};
            if (r < 4)       drive(1, 2'd1, (r == 0) ? rd : {rd[63:3], 3'b0}, $urandom_range(0, 1), 0);
            else if (r < 9)  drive(1, 2'd2, rd, $urandom_range(0, 1), $urandom_range(0, 1));
            else if (r < 13) drive(0, 2'd3, '0, 1, $urandom_range(0, 1));
            else if (r == 13) drive(1, 2'd0, {47'b0, rd[0] & rd[1], 16'b0}, $urandom_range(0, 1), 0);
            else              drive(0, 2'd3, '0, 0, 1);
        end
        idle(2);
        finish_run();
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule